// File: doc/BRIEF.md
# Trigger-Go Watchdog Counter

This block is a free-running 16-bit supervision counter that system software must keep clearing. It advances by one on every cycle in which its synchronised tick enable is high, but only after an initialisation strobe has armed it. Once armed, there is no way for software to stop it. Software can only return it to zero. If software fails to clear it in time, the count wraps past its all-ones value. The counter then halts at zero and drops an active-low "go" status line.

The status line stays low and the counter stays halted until software issues the clear command. A clear also restarts counting from zero. A separate external disable input freezes the count while it is held high. Counting continues from the frozen value when the input is released, unless an overflow halt is latched. The system's reaction to the status line lies outside this block.

Top module: `wdog_trig_counter`

## Requirements
- R1: After the synchronous reset, `count` is 0 and `go_n` is 1. Until `init_go` has been seen, tick pulses leave `count` at 0.
- R2: Once armed by `init_go`, each cycle with `tick_en`=1, `tmr_disable`=0 and `sw_clear`=0 raises `count` by exactly 1 at the next clock edge. The cycle carrying `init_go` itself does not count.
- R3: A cycle with `tick_en`=0 leaves `count` unchanged.
- R4: While `tmr_disable`=1, `count` holds its value. After release, counting resumes from that held value.
- R5: A counting tick at `count`=0xFFFF makes `count` 0 and `go_n` 0 at the same clock edge.
- R6: After overflow, `count` stays 0 and `go_n` stays 0 whatever `tick_en`, `tmr_disable` or `init_go` do, until `sw_clear` arrives.
- R7: `sw_clear` sets `count` to 0 and `go_n` to 1 at the next edge. It wins over a tick in the same cycle. Counting then resumes from 0.
- R8: `sw_clear` before the counter is armed does not arm it: `count` stays 0 under later ticks.
- R9: No command stops an armed counter. A repeated `init_go` neither clears nor stops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Synchronised watchdog tick, one count per high cycle |
| init_go | input | 1 | Initialisation strobe that arms counting |
| sw_clear | input | 1 | Software clear: zero the count and release the overflow halt |
| tmr_disable | input | 1 | External disable, freezes the count while high |
| go_n | output | 1 | Active-low status, low after overflow until cleared |
| count | output | CNT_W | Current count value (16 bits by default) |

## Verification
The assertions check the following on every cycle:
- the single-step increment,
- the hold under a low tick or an asserted disable,
- the wrap-to-halt transition and the falling status line landing on a zero count,
- the halt persisting,
- the clear restoring zero with status high.

Other behaviour depends on hidden arming state that the ports do not show, and only the bench's scenarios can show it:
- that ticks do nothing before arming,
- that a pre-arm clear does not arm the counter,
- that a second init strobe neither clears nor stops the count,
- that counting resumes after a clear.

A full 65,536-tick run reaches the real overflow at the default width.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_HALT = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic init_go,
  input  logic sw_clear,
  input  logic tmr_disable,
  input  logic at_max,
  output logic cnt_inc,
  output logic cnt_zero,
  output logic trip
);
  wd_state_e state_q, state_d;
  logic running;

  always_comb begin
    running  = (state_q == WD_RUN);
    cnt_inc  = running && tick_en && !tmr_disable && !sw_clear;
    trip     = cnt_inc && at_max;
    cnt_zero = sw_clear;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      WD_IDLE: if (init_go && !sw_clear) state_d = WD_RUN;
      WD_RUN:  if (trip) state_d = WD_HALT;
      WD_HALT: if (sw_clear) state_d = WD_RUN;
      default: state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= WD_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_inc,
  input  logic             cnt_zero,
  output logic [CNT_W-1:0] count,
  output logic             at_max
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_zero) count_q <= '0;
    else if (cnt_inc)    count_q <= count_q + CNT_ONE;
  end

  assign count  = count_q;
  assign at_max = (count_q == CNT_MAX);
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst,
  input  logic cnt_zero,
  input  logic trip,
  output logic go_n
);
  logic go_n_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_zero) go_n_q <= 1'b1;
    else if (trip)       go_n_q <= 1'b0;
  end

  assign go_n = go_n_q;
endmodule

// File: rtl/wdog_trig_counter.sv
module wdog_trig_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             init_go,
  input  logic             sw_clear,
  input  logic             tmr_disable,
  output logic             go_n,
  output logic [CNT_W-1:0] count
);
  logic cnt_inc, cnt_zero, trip, at_max;

  wdog_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tick_en(tick_en), .init_go(init_go),
    .sw_clear(sw_clear), .tmr_disable(tmr_disable), .at_max(at_max),
    .cnt_inc(cnt_inc), .cnt_zero(cnt_zero), .trip(trip)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_inc(cnt_inc), .cnt_zero(cnt_zero),
    .count(count), .at_max(at_max)
  );

  wdog_status u_stat (
    .clk(clk), .rst(rst), .cnt_zero(cnt_zero), .trip(trip), .go_n(go_n)
  );
endmodule

// File: rtl/wdog_trig_counter_chk.sv
module wdog_trig_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             init_go,
  input logic             sw_clear,
  input logic             tmr_disable,
  input logic             go_n,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (count == '0 && go_n)); // R1
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && count != CNT_MAX && tick_en && !tmr_disable && !sw_clear)
    |=> count == $past(count) + CNT_ONE); // R2
  AST_TICK_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !sw_clear) |=> $stable(count)); // R3
  AST_DISABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tmr_disable && !sw_clear) |=> $stable(count)); // R4
  AST_WRAP_TRIP: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && tick_en && !tmr_disable && !sw_clear)
    |=> (count == '0 && !go_n)); // R5
  AST_FALL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(go_n) |-> count == '0); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!go_n && !sw_clear) |=> (!go_n && count == '0)); // R6
  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (rst)
    sw_clear |=> (count == '0 && go_n)); // R7
  initial assert (CNT_W >= 2); // R5 width sanity
  logic unused_init;
  assign unused_init = init_go;
endmodule

bind wdog_trig_counter wdog_trig_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .init_go(init_go),
  .sw_clear(sw_clear), .tmr_disable(tmr_disable), .go_n(go_n), .count(count)
);

// File: tb/wdog_trig_counter_test.sv
module wdog_trig_counter_test;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, init_go = 1'b0, sw_clear = 1'b0, tmr_disable = 1'b0;
  logic go_n;
  logic [CNT_W-1:0] count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state: 0 idle, 1 armed, 2 halted
  int m_state = 0;
  logic [CNT_W-1:0] m_cnt = '0;
  logic m_gon = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  wdog_trig_counter #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .init_go(init_go),
    .sw_clear(sw_clear), .tmr_disable(tmr_disable), .go_n(go_n), .count(count)
  );

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  task automatic model_update();
    if (rst) begin
      m_state = 0; m_cnt = '0; m_gon = 1'b1;
    end else if (sw_clear) begin
      m_cnt = '0; m_gon = 1'b1;
      if (m_state != 0) m_state = 1;
    end else if (m_state == 0) begin
      if (init_go) m_state = 1;
    end else if (m_state == 1) begin
      if (tick_en && !tmr_disable) begin
        if (m_cnt == CNT_MAX) begin
          m_cnt = '0; m_gon = 1'b0; m_state = 2;
        end else m_cnt = next_cnt(m_cnt);
      end
    end
  endtask

  task automatic step(input logic t, input logic i, input logic c, input logic d);
    @(negedge clk);
    tick_en = t; init_go = i; sw_clear = c; tmr_disable = d;
    @(posedge clk);
    #1;
    model_update();
  endtask

  task automatic chk(input string tag, input logic [CNT_W-1:0] ec, input logic eg);
    n_chk++;
    if (count !== ec || go_n !== eg) begin
      n_fail++;
      $display("FAIL %s: count=%h go_n=%b expected count=%h go_n=%b", tag, count, go_n, ec, eg);
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step(0, 0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0, 0);
    chk("R1 reset state", '0, 1'b1);
    repeat (5) step(1, 0, 0, 0);
    chk("R1 ticks before arming", '0, 1'b1);
    step(0, 0, 1, 0);
    repeat (4) step(1, 0, 0, 0);
    chk("R8 clear does not arm", '0, 1'b1);
    step(1, 1, 0, 0);
    chk("R2 init cycle does not count", '0, 1'b1);
    repeat (10) step(1, 0, 0, 0);
    chk("R2 ten ticks", 16'd10, 1'b1);
    repeat (3) step(0, 0, 0, 0);
    chk("R3 tick low holds", 16'd10, 1'b1);
    repeat (4) step(1, 0, 0, 1);
    chk("R4 disable holds", 16'd10, 1'b1);
    repeat (2) step(1, 0, 0, 0);
    chk("R4 resume after release", 16'd12, 1'b1);
    step(1, 1, 0, 0);
    chk("R9 repeated init keeps counting", 16'd13, 1'b1);
    step(1, 0, 1, 0);
    chk("R7 clear wins over tick", '0, 1'b1);
    step(1, 0, 0, 0);
    chk("R7 counting resumes after clear", 16'd1, 1'b1);

    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom % 100);
      logic t = (r < 70);
      logic d = (($urandom % 100) < 10);
      logic c = (($urandom % 100) < 1);
      logic i = (($urandom % 100) < 2);
      step(t, i, c, d);
      chk("R2/R3/R4/R7/R9 random", m_cnt, m_gon);
    end

    step(0, 0, 1, 0);
    for (int k = 0; k < 65535; k++) step(1, 0, 0, 0);
    chk("R5 reached all ones", CNT_MAX, 1'b1);
    step(1, 0, 0, 0);
    chk("R5 overflow trips", '0, 1'b0);
    repeat (5) step(1, 0, 0, 0);
    chk("R6 ticks ignored when halted", '0, 1'b0);
    step(1, 1, 0, 1);
    step(1, 0, 0, 0);
    chk("R6 init and disable ignored when halted", '0, 1'b0);
    step(0, 0, 1, 0);
    chk("R7 clear releases halt", '0, 1'b1);
    repeat (3) step(1, 0, 0, 0);
    chk("R7 counts after halt release", 16'd3, 1'b1);
    chk("model agreement after overflow", m_cnt, m_gon);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule